// File: doc/BRIEF.md
# Vertical Blank Interrupt Controller

This block raises one level-sensitive interrupt line from a status register that is masked by an enable register. A programmable frame-period counter stands in for the display's roughly 60 Hz frame event. Each time the counter wraps, the frame-event bit in status is set. Other interrupt sources are not generated here. They reach status only as single-cycle set pulses on a dedicated input.

Software reaches the two registers through a one-cycle write strobe and a combinational read mux. Status is write-1-to-clear. A model-select input chooses which of two clear masks applies, so bits outside the mask stay set whatever is written. Writing the enable register also drives the frame counter:
- With the frame-event enable bit set, the write asserts the frame-event status bit at once and restarts the counter from zero.
- With that bit clear, the write halts the counter.

Top module: `vbl_irq_ctrl`

## Requirements
- R1: `irq` is high exactly when the bitwise AND of the status and enable registers is non-zero. It follows any register change on the next clock edge.
- R2: While the frame counter runs, status bit 0 is set once every `PERIOD` clock cycles. The first set comes `PERIOD` edges after the enabling write.
- R3: A write to the enable register (`wr_sel`=0) with data bit 0 equal to 1 sets status bit 0 on that edge. It also restarts the frame counter from zero, so the next periodic set comes `PERIOD` edges later.
- R4: A write to the enable register with data bit 0 equal to 0 halts the frame counter. No periodic set occurs afterwards, including on the edge of the write.
- R5: A write to the status register (`wr_sel`=1) clears each status bit written as 1 that lies in the active clear mask. Bits written as 0 are unchanged.
- R6: `model_sel`=0 selects clear mask 0x000F040F and `model_sel`=1 selects 0xFC080EFF. Status bits outside the selected mask cannot be cleared.
- R7: Each bit of `src_set` high for one cycle sets the matching status bit. When a set and a clear hit the same bit on the same edge, the set wins.
- R8: `rd_data` shows the enable register when `rd_sel`=0 and the status register when `rd_sel`=1, combinationally.
- R9: Asserting `rst_n` low clears enable and status at once, halts the counter and drives `irq` low. Release takes effect on the third clock edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| model_sel | input | 1 | Selects the status clear mask |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_sel | input | 1 | Write target: 0 enable, 1 status |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 enable, 1 status |
| rd_data | output | 32 | Read data |
| src_set | input | 32 | Per-bit status set pulses from other sources |
| irq | output | 1 | Level interrupt output |

## Verification
A wrong frame-counter value shows up as a frame-event bit that appears one or more edges away from the expected edge. A per-cycle reference comparison therefore catches it on the first wrongly timed set, within one frame period. A wrong clear mask or a wrong set/clear priority leaves a status bit different from the expected value on the edge right after the write. It is visible on `rd_data` and, when enabled, on `irq`. A halted counter that keeps counting is caught by a status bit that reappears during the long idle window after the disable write.

// File: rtl/vbl_irq_pkg.sv
package vbl_irq_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [DATA_W-1:0] CLR_MASK_M0 = 32'h000F_040F;
  localparam logic [DATA_W-1:0] CLR_MASK_M1 = 32'hFC08_0EFF;
  localparam int unsigned FRAME_BIT = 0;

  typedef enum logic {SEL_ENABLE = 1'b0, SEL_STATUS = 1'b1} reg_sel_e;

  function automatic logic [DATA_W-1:0] clr_mask(input logic model);
    return model ? CLR_MASK_M1 : CLR_MASK_M0;
  endfunction
endpackage

// File: rtl/vbl_rst_sync.sv
module vbl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/vbl_frame_timer.sv
module vbl_frame_timer #(
  parameter int unsigned PERIOD = 1666667
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic halt,
  output logic tick,
  output logic running
);
  localparam int unsigned CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             wrap;

  assign wrap = run_q && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    tick  = 1'b0;
    if (restart) begin
      cnt_d = '0;
      run_d = 1'b1;
    end else if (halt) begin
      cnt_d = '0;
      run_d = 1'b0;
    end else if (run_q) begin
      if (wrap) begin
        cnt_d = '0;
        tick  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign running = run_q;
endmodule

// File: rtl/vbl_irq_regs.sv
module vbl_irq_regs
  import vbl_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              model_sel,
  input  logic              en_wr,
  input  logic              st_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] src_set,
  input  logic              tick,
  output logic [DATA_W-1:0] enable_q,
  output logic [DATA_W-1:0] status_q,
  output logic              irq
);
  logic [DATA_W-1:0] enable_d, status_d;
  logic [DATA_W-1:0] set_vec, clr_vec;

  always_comb begin
    set_vec = src_set;
    set_vec[FRAME_BIT] = src_set[FRAME_BIT] | tick | (en_wr & wr_data[FRAME_BIT]);
    clr_vec = st_wr ? (wr_data & clr_mask(model_sel)) : '0;
    status_d = (status_q & ~clr_vec) | set_vec;
    enable_d = en_wr ? wr_data : enable_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      status_q <= '0;
    end else begin
      enable_q <= enable_d;
      status_q <= status_d;
    end
  end

  assign irq = |(status_q & enable_q);
endmodule

// File: rtl/vbl_irq_ctrl.sv
module vbl_irq_ctrl
  import vbl_irq_pkg::*;
#(
  parameter int unsigned PERIOD = 1666667
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              model_sel,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] src_set,
  output logic              irq
);
  logic              rst_sync_n;
  logic              en_wr, st_wr;
  logic              tick, running;
  logic [DATA_W-1:0] enable_q, status_q;

  assign en_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_ENABLE);
  assign st_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_STATUS);

  vbl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  vbl_frame_timer #(.PERIOD(PERIOD)) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .restart (en_wr && wr_data[FRAME_BIT]),
    .halt    (en_wr && !wr_data[FRAME_BIT]),
    .tick    (tick),
    .running (running)
  );

  vbl_irq_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .model_sel (model_sel),
    .en_wr     (en_wr),
    .st_wr     (st_wr),
    .wr_data   (wr_data),
    .src_set   (src_set),
    .tick      (tick),
    .enable_q  (enable_q),
    .status_q  (status_q),
    .irq       (irq)
  );

  assign rd_data = (reg_sel_e'(rd_sel) == SEL_STATUS) ? status_q : enable_q;
endmodule

// File: rtl/vbl_irq_chk.sv
module vbl_irq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        model_sel,
  input logic        wr_en,
  input logic        wr_sel,
  input logic [31:0] wr_data,
  input logic [31:0] src_set,
  input logic [31:0] status_q,
  input logic        tick,
  input logic        running,
  input logic        irq
);
  AST_ENABLE_SETS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wr_data[0]) |=> (status_q[0] && irq)); // R3

  AST_DISABLE_ALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && (wr_data == 32'h0)) |=> !irq); // R1

  AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && !wr_data[0]) |=> (!tick && !running)); // R4

  AST_W1C_BIT1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && wr_data[1] && !src_set[1]) |=> !status_q[1]); // R5

  AST_MASK_KEEPS_BIT4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && !model_sel && status_q[4]) |=> status_q[4]); // R6

  AST_SET_PULSE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    src_set[2] |=> status_q[2]); // R7
endmodule

bind vbl_irq_ctrl vbl_irq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .model_sel (model_sel),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .src_set   (src_set),
  .status_q  (status_q),
  .tick      (tick),
  .running   (running),
  .irq       (irq)
);

// File: tb/vbl_irq_ctrl_bench.sv
module vbl_irq_ctrl_bench;
  localparam int P = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        model_sel = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic [31:0] src_set = '0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vbl_irq_ctrl #(.PERIOD(P)) u_vbl_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .model_sel(model_sel), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .src_set(src_set), .irq(irq));

  // behavioural reference
  logic [31:0] m_en = '0, m_st = '0;
  int m_cnt = 0, m_sync = 0;
  bit m_run = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= '0; m_st <= '0; m_cnt <= 0; m_run <= 1'b0; m_sync <= 0;
    end else if (m_sync < 2) begin
      m_sync <= m_sync + 1;
    end else begin
      logic [31:0] st;
      logic [31:0] msk;
      msk = model_sel ? 32'hFC08_0EFF : 32'h000F_040F;
      st = m_st;
      if (wr_en && wr_sel) st = st & ~(wr_data & msk);
      st = st | src_set;
      if (wr_en && !wr_sel) begin
        m_en <= wr_data;
        m_cnt <= 0;
        m_run <= wr_data[0];
        if (wr_data[0]) st[0] = 1'b1;
      end else if (m_run) begin
        if (m_cnt == P - 1) begin
          m_cnt <= 0;
          st[0] = 1'b1;
        end else begin
          m_cnt <= m_cnt + 1;
        end
      end
      m_st <= st;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #4;
    if (cmp_on) begin
      check("R8 rd_data vs model", rd_data, rd_sel ? m_st : m_en);
      check("R1 irq vs model", {31'b0, irq}, {31'b0, |(m_st & m_en)});
    end
  end

  // caller is at a negedge; drive now, release at the next negedge
  task automatic wr(input logic sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input logic [31:0] s);
    src_set = s;
    @(negedge clk);
    src_set = '0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input string tag, input logic sel, input logic [31:0] exp);
    rd_sel = sel;
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(4);
    cmp_on = 1'b1;
    rd("R9 enable after reset", 1'b0, 32'h0);
    rd("R9 status after reset", 1'b1, 32'h0);
    check("R9 irq after reset", {31'b0, irq}, 32'h0);
    step(1);

    pulse(32'h10);
    rd("R7 set pulse bit4", 1'b1, 32'h10);
    check("R1 irq low with enable zero", {31'b0, irq}, 32'h0);
    step(1);

    wr(1'b0, 32'h10);
    #1 check("R1 irq high once bit4 enabled", {31'b0, irq}, 32'h1);
    step(1);

    model_sel = 1'b0;
    wr(1'b1, 32'hFFFF_FFFF);
    rd("R6 model0 keeps bit4", 1'b1, 32'h10);
    step(1);
    model_sel = 1'b1;
    wr(1'b1, 32'h10);
    rd("R6 model1 clears bit4", 1'b1, 32'h0);
    check("R1 irq drops after clear", {31'b0, irq}, 32'h0);
    step(1);

    pulse(32'h3);
    wr(1'b1, 32'h2);
    rd("R5 only written bit cleared", 1'b1, 32'h1);
    wr(1'b1, 32'h1);
    rd("R5 bit0 cleared", 1'b1, 32'h0);

    src_set = 32'h4;
    wr(1'b1, 32'h4);
    src_set = '0;
    rd("R7 set beats clear", 1'b1, 32'h4);
    wr(1'b1, 32'h4);

    // periodic frame event
    wr(1'b0, 32'h1);
    rd("R3 enable write sets frame bit", 1'b1, 32'h1);
    check("R3 irq after enable", {31'b0, irq}, 32'h1);
    wr(1'b1, 32'h1);
    step(P - 2);
    rd("R2 no frame event before period", 1'b1, 32'h0);
    step(1);
    rd("R2 frame event at period", 1'b1, 32'h1);
    check("R2 irq at period", {31'b0, irq}, 32'h1);

    // restart mid-frame
    step(5);
    wr(1'b0, 32'h1);
    wr(1'b1, 32'h1);
    step(P - 2);
    rd("R3 restart delays next event", 1'b1, 32'h0);
    step(1);
    rd("R3 event one period after restart", 1'b1, 32'h1);

    // halt
    wr(1'b0, 32'h0);
    wr(1'b1, 32'h1);
    step(3 * P);
    rd("R4 no event after halt", 1'b1, 32'h0);
    check("R4 irq stays low", {31'b0, irq}, 32'h0);

    // asynchronous reset mid-run
    wr(1'b0, 32'h1);
    step(3);
    rst_n = 1'b0;
    rd("R9 status cleared by async reset", 1'b1, 32'h0);
    check("R9 irq low in reset", {31'b0, irq}, 32'h0);
    step(2);
    rst_n = 1'b1;
    step(P + 3);
    rd("R9 timer halted after reset", 1'b1, 32'h0);
    rd("R9 enable zero after reset", 1'b0, 32'h0);
    step(2);

    done = 1'b1;
    summary();
  end
endmodule